// File: doc/BRIEF.md
# Clock-Gated Register File

This block is a small register file of byte-wide rows. One write port and one read port share a single clock. A write stores a byte into the row picked by the write address at the next rising clock edge. A read returns the row picked by the read address through a combinational multiplexer. Only one row can change per edge, and only while the write enable is high.

A compile-time switch picks how an idle row keeps its contents.

- In the gated build, each row's flops run on a private clock. That clock is the main clock ORed with the inverse of the row's own write term. A row that is not being written therefore sees a clock parked high, and gets no rising edge.
- In the ungated build, every row runs on the main clock. A two-way selector at the row input feeds the stored word back unless the row is being written.

Both builds behave the same at the ports. The row write term comes from logic on the same clock's rising edge. It may wander during the high phase of the clock, provided it is settled before the falling edge.

Top module: `cg_regfile`

## Requirements
- R1: An active-low `rst_n` clears every row to 0x00 as soon as it is asserted, without waiting for a clock edge and whatever the state of the row clocks.
- R2: With `wr_en` = 1 at a rising edge of `clk`, row `w_addr` holds `w_data` after that edge.
- R3: A write changes only the row at `w_addr`; every other row keeps its value across that edge.
- R4: With `wr_en` = 0 at a rising edge, no row changes, whatever `w_addr` and `w_data` carry.
- R5: `r_data` equals the row at `r_addr` combinationally. A read of the row being written in the same cycle returns the old word until the edge.
- R6: With `GATE_ROWS` = 1, a row's clock is `clk` OR NOT(row write term). A pulse on `wr_en` confined to the high phase of `clk` writes nothing.
- R7: The gated build (`GATE_ROWS` = 1) and the feedback build (`GATE_ROWS` = 0) give identical `r_data` for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, all logic on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all rows |
| wr_en | input | 1 | 1 = write cycle, 0 = read-only cycle |
| w_addr | input | AW = clog2(DEPTH) | Row to write |
| w_data | input | 8 | Byte to store |
| r_addr | input | AW | Row to read |
| r_data | output | 8 | Contents of row `r_addr` |

## Verification
The bound checker watches the flattened row contents on every rising edge. It checks four things:
- a write lands in the addressed row;
- no other row moves during a write;
- nothing moves in a read-only cycle;
- the read port shows the addressed row.

What the checker cannot see happens between edges. Only the bench scenarios show the following:
- the same-cycle read returning the old word;
- the asynchronous clear taking effect mid-cycle;
- the absence of a write after a write-enable pulse injected during the clock-high phase;
- agreement between the gated and feedback builds.

// File: rtl/cg_regfile_pkg.sv
`timescale 1ns/1ps
package cg_regfile_pkg;
    localparam int WORD_W = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t word;
    } row_state_t;
endpackage

// File: rtl/cg_regfile_wdec.sv
`timescale 1ns/1ps
module cg_regfile_wdec #(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    w_addr,
    output logic [DEPTH-1:0] row_en
);
    // One-hot row write terms; an address past DEPTH selects no row.
    always_comb begin
        row_en = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (w_addr == AW'(i))) begin
                row_en[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cg_regfile_row.sv
`timescale 1ns/1ps
module cg_regfile_row
    import cg_regfile_pkg::*;
#(
    parameter bit GATE_ROWS = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  row_en,
    input  word_t w_data,
    output word_t row_q
);
    row_state_t st_d, st_q;

    generate
        if (GATE_ROWS) begin : g_gated
            // OR-style gate: idle row clock parks high, so no rising edge.
            logic gclk;
            assign gclk = clk | ~row_en;

            always_comb begin
                st_d      = st_q;
                st_d.word = w_data;
            end

            always_ff @(posedge gclk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_hold
            // Free-running clock with a feedback selector at the row input.
            always_comb begin
                st_d = st_q;
                if (row_en) begin
                    st_d.word = w_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

    assign row_q = st_q.word;
endmodule

// File: rtl/cg_regfile_rmux.sv
`timescale 1ns/1ps
module cg_regfile_rmux
    import cg_regfile_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    localparam int FLAT_W = DEPTH * WORD_W
) (
    input  logic [FLAT_W-1:0] rows_flat,
    input  logic [AW-1:0]     r_addr,
    output word_t             r_data
);
    always_comb begin
        r_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (r_addr == AW'(i)) begin
                r_data = rows_flat[i*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/cg_regfile.sv
`timescale 1ns/1ps
module cg_regfile
    import cg_regfile_pkg::*;
#(
    parameter int  DEPTH     = 8,
    parameter bit  GATE_ROWS = 1'b1,
    localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     w_addr,
    input  logic [WORD_W-1:0] w_data,
    input  logic [AW-1:0]     r_addr,
    output logic [WORD_W-1:0] r_data
);
    localparam int FLAT_W = DEPTH * WORD_W;

    logic [DEPTH-1:0]  row_en;
    logic [FLAT_W-1:0] rows_flat;

    cg_regfile_wdec #(.DEPTH(DEPTH), .AW(AW)) u_wdec (
        .wr_en  (wr_en),
        .w_addr (w_addr),
        .row_en (row_en)
    );

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_row
            word_t q;
            cg_regfile_row #(.GATE_ROWS(GATE_ROWS)) u_row (
                .clk    (clk),
                .rst_n  (rst_n),
                .row_en (row_en[i]),
                .w_data (w_data),
                .row_q  (q)
            );
            assign rows_flat[i*WORD_W +: WORD_W] = q;
        end
    endgenerate

    cg_regfile_rmux #(.DEPTH(DEPTH), .AW(AW)) u_rmux (
        .rows_flat (rows_flat),
        .r_addr    (r_addr),
        .r_data    (r_data)
    );
endmodule

// File: rtl/cg_regfile_chk.sv
`timescale 1ns/1ps
module cg_regfile_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int W     = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [AW-1:0]      w_addr,
    input logic [W-1:0]       w_data,
    input logic [AW-1:0]      r_addr,
    input logic [W-1:0]       r_data,
    input logic [DEPTH*W-1:0] rows_flat
);
    logic [DEPTH*W-1:0] wmask;
    assign wmask = {{(DEPTH*W-W){1'b0}}, {W{1'b1}}} << (int'(w_addr) * W);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(w_addr) < DEPTH) |=>
            rows_flat[int'($past(w_addr))*W +: W] == $past(w_data));

    // R3
    others_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rows_flat ^ $past(rows_flat)) & ~$past(wmask)) == '0);

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rows_flat));

    // R5
    read_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(r_addr) < DEPTH) |-> r_data == rows_flat[int'(r_addr)*W +: W]);
endmodule

bind cg_regfile cg_regfile_chk #(.DEPTH(DEPTH), .AW(AW), .W(8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .w_addr    (w_addr),
    .w_data    (w_data),
    .r_addr    (r_addr),
    .r_data    (r_data),
    .rows_flat (rows_flat)
);

// File: tb/tb_cg_regfile.sv
`timescale 1ns/1ps
module tb_cg_regfile;
    localparam int DEPTH = 8;
    localparam int AW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] w_addr = '0;
    logic [7:0]    w_data = '0;
    logic [AW-1:0] r_addr = '0;
    logic [7:0]    r_data, r_data_mux;

    logic [7:0] ref_rows [DEPTH];
    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cg_regfile #(.DEPTH(DEPTH), .GATE_ROWS(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .w_addr(w_addr),
        .w_data(w_data), .r_addr(r_addr), .r_data(r_data)
    );

    cg_regfile #(.DEPTH(DEPTH), .GATE_ROWS(1'b0)) dut_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .w_addr(w_addr),
        .w_data(w_data), .r_addr(r_addr), .r_data(r_data_mux)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Read every row through the port on both builds and compare with the model.
    task automatic sweep(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            r_addr = AW'(a);
            #0.1;
            check(tag, r_data, ref_rows[a]);
            check({tag, " R7 mux build"}, r_data_mux, ref_rows[a]);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en  = 1'b1;
        w_addr = AW'(a);
        w_data = d;
        r_addr = AW'(a);
        @(negedge clk); #0.2;
        check("R5 same-cycle read old word", r_data, ref_rows[a]);
        check("R5/R7 same-cycle read mux build", r_data_mux, ref_rows[a]);
        @(posedge clk); #1;
        wr_en = 1'b0;
        ref_rows[a] = d;
        check("R2 written word visible", r_data, d);
        check("R2/R7 written word visible mux build", r_data_mux, d);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_rows[a] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        sweep("R1 reset clears rows");
        rst_n = 1'b1;

        // Pass 1: each address, arithmetic pattern; full sweep checks R3.
        for (int a = 0; a < DEPTH; a++) begin
            do_write(a, 8'((a * 37 + 5) & 8'hff));
            sweep("R3 other rows kept");
        end

        // Read-only cycles with busy address/data lines.
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            wr_en  = 1'b0;
            w_addr = AW'(k);
            w_data = 8'(8'hA0 + k);
        end
        @(posedge clk); #1;
        sweep("R4 idle cycles change nothing");

        // Enable pulses confined to the clock-high phase.
        for (int a = 0; a < DEPTH; a++) begin
            @(posedge clk); #0.5;
            wr_en  = 1'b1;
            w_addr = AW'(a);
            w_data = 8'(~a);
            #0.6;
            wr_en = 1'b0;
        end
        @(posedge clk); #1;
        sweep("R6 high-phase glitch writes nothing");

        // Pass 2: inverted pattern in reverse order, with repeated rewrites.
        for (int a = DEPTH - 1; a >= 0; a--) begin
            do_write(a, 8'(~((a * 37 + 5) & 8'hff)));
        end
        do_write(2, 8'h5A);
        do_write(2, 8'hC3);
        sweep("R3 after pass 2");

        // Mid-cycle asynchronous clear.
        @(posedge clk); #1.3;
        rst_n = 1'b0;
        #0.3;
        for (int a = 0; a < DEPTH; a++) ref_rows[a] = 8'h00;
        sweep("R1 async clear mid-cycle");
        @(posedge clk); #1;
        rst_n = 1'b1;
        do_write(5, 8'h81);
        sweep("R2 write after clear");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule